// File: doc/BRIEF.md
# Streaming 16-bit MOV Instruction Decoder

This block takes a stream of instruction bytes, one byte per accepted transfer, and decodes two 16-bit real-mode data-move forms. The first is the register/memory move, whose opcode byte has a direction bit and a width bit. The second is the immediate-to-memory move. After the opcode it reads the operand-descriptor byte. That byte's mode field and register/memory field decide how many displacement bytes follow, whether the operand is a register or a memory location, which base and index registers form the address, and which segment applies by default.

When the last byte of an instruction has been taken, the block presents one decoded record and holds it until the consumer accepts it. No further bytes are taken while the record waits. Alongside the record it forms a 16-bit effective address from the base and index register values on its inputs and the sign-extended displacement. A first byte that is neither supported form raises a one-cycle illegal flag, and the next byte is treated as a fresh opcode.

Top module: `mov_stream_decoder`

## Requirements
- R1: An opcode byte whose bits 7:2 are 100010 starts a register/memory move. Its bit 1 is reported as `out_dir` (1 = data flows into the REG operand) and its bit 0 as `out_wide` (1 = word, 0 = byte).
- R2: The second byte is split into mode (bits 7:6), REG (bits 5:3) and R/M (bits 2:0). REG is reported unchanged on `out_reg`. Mode 11 reports `out_is_mem` = 0, with no base, no index, zero displacement and an effective address of 0.
- R3: Mode 00 takes no displacement byte. Mode 01 takes one byte, sign-extended to 16 bits. Mode 10 takes two bytes, low byte first. The value appears on `out_disp`.
- R4: For memory modes, R/M 000..111 select BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX. `out_base_sel` is coded 0 none, 1 BX, 2 BP. `out_idx_sel` is coded 0 none, 1 SI, 2 DI. `out_seg_ss` is 1 exactly when BP is the base.
- R5: Mode 00 with R/M 110 is direct addressing. It takes two displacement bytes, low first, and uses no base, no index and the data segment (`out_seg_ss` = 0).
- R6: An opcode byte 1100011W starts an immediate move with `out_dir` = 0 and `out_imm_form` = 1. Its second byte must have REG = 000, or the illegal flag is raised and the instruction is dropped. After any displacement come one data byte, zero-extended (W=0), or two data bytes, low byte first (W=1), on `out_imm`. The register/memory form reports `out_imm` = 0.
- R7: `out_len` equals the number of bytes in the instruction: 2 plus displacement bytes plus data bytes.
- R8: `out_ea` is the 16-bit wrap-around sum of the selected base register, the selected index register and `out_disp`. It follows the register inputs combinationally while the record is shown.
- R9: An opcode byte that matches neither form sets `out_illegal` for exactly one cycle. The byte that follows is decoded as a new opcode.
- R10: `out_valid` rises in the cycle after the last byte of an instruction is taken. It stays high with a stable record until a cycle with `out_ready` high. `in_ready` is low while it is high, so bytes offered then are not consumed.
- R11: A synchronous active-high `rst` discards any partly received instruction. It clears `out_valid` and `out_illegal` and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| reg_bx | input | 16 | Current BX value |
| reg_bp | input | 16 | Current BP value |
| reg_si | input | 16 | Current SI value |
| reg_di | input | 16 | Current DI value |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer accepts the record |
| out_illegal | output | 1 | One-cycle pulse on an unsupported opcode or bad REG |
| out_dir | output | 1 | 1 = into REG operand |
| out_wide | output | 1 | 1 = word operand |
| out_imm_form | output | 1 | 1 = immediate form |
| out_reg | output | 3 | REG field |
| out_is_mem | output | 1 | 1 = R/M names memory |
| out_base_sel | output | 2 | 0 none, 1 BX, 2 BP |
| out_idx_sel | output | 2 | 0 none, 1 SI, 2 DI |
| out_seg_ss | output | 1 | 1 = stack segment default, 0 = data segment |
| out_disp | output | 16 | Sign-extended displacement |
| out_imm | output | 16 | Immediate data |
| out_len | output | 4 | Instruction length in bytes |
| out_ea | output | 16 | Effective address |

## Verification
A parser that takes a wrong branch after the operand byte shows up at the record. It either emits one transfer early with a short `out_len`, or it keeps consuming bytes so that the next instruction's opcode lands in a displacement or data field and every later record is corrupt. A broken mode-to-register table shows in the same cycle `out_valid` rises, through wrong base, index or segment codes and an effective address that disagrees with the register inputs. Mishandled hold or illegal-flag logic shows within one cycle, as a record that changes while waiting, a byte consumed while the record waits, or a flag that lasts more or less than one cycle.

// File: rtl/movdec_pkg.sv
package movdec_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned LEN_W  = 4;
    localparam int unsigned SEL_W  = 2;

    localparam logic [SEL_W-1:0] SEL_NONE = 2'd0;
    localparam logic [SEL_W-1:0] BASE_BX  = 2'd1;
    localparam logic [SEL_W-1:0] BASE_BP  = 2'd2;
    localparam logic [SEL_W-1:0] IDX_SI   = 2'd1;
    localparam logic [SEL_W-1:0] IDX_DI   = 2'd2;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_MODRM,
        ST_DLO,
        ST_DHI,
        ST_ILO,
        ST_IHI,
        ST_EMIT
    } pstate_e;

    typedef struct packed {
        logic              dir;
        logic              wide;
        logic              imm_form;
        logic [1:0]        mode;
        logic [2:0]        regf;
        logic [2:0]        rm;
        logic [WORD_W-1:0] disp;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
    } rec_t;

    function automatic logic [1:0] disp_bytes(input logic [1:0] mode, input logic [2:0] rm);
        logic [1:0] n;
        case (mode)
            2'b00:   n = (rm == 3'b110) ? 2'd2 : 2'd0;
            2'b01:   n = 2'd1;
            2'b10:   n = 2'd2;
            default: n = 2'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/movdec_rm_decode.sv
module movdec_rm_decode
    import movdec_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic [2:0]       rm,
    output logic             is_mem,
    output logic [SEL_W-1:0] base_sel,
    output logic [SEL_W-1:0] idx_sel,
    output logic             seg_ss
);

    always_comb begin
        is_mem   = (mode != 2'b11);
        base_sel = SEL_NONE;
        idx_sel  = SEL_NONE;
        if (is_mem) begin
            case (rm)
                3'b000: begin base_sel = BASE_BX; idx_sel = IDX_SI; end
                3'b001: begin base_sel = BASE_BX; idx_sel = IDX_DI; end
                3'b010: begin base_sel = BASE_BP; idx_sel = IDX_SI; end
                3'b011: begin base_sel = BASE_BP; idx_sel = IDX_DI; end
                3'b100: idx_sel = IDX_SI;
                3'b101: idx_sel = IDX_DI;
                3'b110: base_sel = (mode == 2'b00) ? SEL_NONE : BASE_BP;
                default: base_sel = BASE_BX;
            endcase
        end
        seg_ss = (base_sel == BASE_BP);
    end

endmodule

// File: rtl/movdec_ea_adder.sv
module movdec_ea_adder
    import movdec_pkg::*;
(
    input  logic [SEL_W-1:0]  base_sel,
    input  logic [SEL_W-1:0]  idx_sel,
    input  logic [WORD_W-1:0] reg_bx,
    input  logic [WORD_W-1:0] reg_bp,
    input  logic [WORD_W-1:0] reg_si,
    input  logic [WORD_W-1:0] reg_di,
    input  logic [WORD_W-1:0] disp,
    output logic [WORD_W-1:0] ea
);

    logic [WORD_W-1:0] base_val;
    logic [WORD_W-1:0] idx_val;

    always_comb begin
        case (base_sel)
            BASE_BX: base_val = reg_bx;
            BASE_BP: base_val = reg_bp;
            default: base_val = '0;
        endcase
        case (idx_sel)
            IDX_SI:  idx_val = reg_si;
            IDX_DI:  idx_val = reg_di;
            default: idx_val = '0;
        endcase
        ea = base_val + idx_val + disp;
    end

endmodule

// File: rtl/movdec_parser.sv
module movdec_parser
    import movdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output rec_t              rec,
    output logic              bad_op
);

    typedef struct packed {
        pstate_e st;
        rec_t    rec;
        logic    bad;
    } pstate_t;

    pstate_t s_d, s_q;
    logic       take;
    logic [1:0] n_disp;
    logic [1:0] n_new_disp;

    always_comb begin
        s_d        = s_q;
        s_d.bad    = 1'b0;
        take       = in_valid && (s_q.st != ST_EMIT);
        n_disp     = disp_bytes(s_q.rec.mode, s_q.rec.rm);
        n_new_disp = disp_bytes(in_byte[7:6], in_byte[2:0]);
        case (s_q.st)
            ST_OPC: begin
                if (take) begin
                    if (in_byte[7:2] == 6'b100010) begin
                        s_d.rec      = '0;
                        s_d.rec.dir  = in_byte[1];
                        s_d.rec.wide = in_byte[0];
                        s_d.rec.len  = LEN_W'(1);
                        s_d.st       = ST_MODRM;
                    end else if (in_byte[7:1] == 7'b1100011) begin
                        s_d.rec          = '0;
                        s_d.rec.imm_form = 1'b1;
                        s_d.rec.wide     = in_byte[0];
                        s_d.rec.len      = LEN_W'(1);
                        s_d.st           = ST_MODRM;
                    end else begin
                        s_d.bad = 1'b1;
                    end
                end
            end
            ST_MODRM: begin
                if (take) begin
                    s_d.rec.mode = in_byte[7:6];
                    s_d.rec.regf = in_byte[5:3];
                    s_d.rec.rm   = in_byte[2:0];
                    s_d.rec.len  = s_q.rec.len + LEN_W'(1);
                    if (s_q.rec.imm_form && (in_byte[5:3] != 3'b000)) begin
                        s_d.bad = 1'b1;
                        s_d.st  = ST_OPC;
                    end else if (n_new_disp != 2'd0) begin
                        s_d.st = ST_DLO;
                    end else if (s_q.rec.imm_form) begin
                        s_d.st = ST_ILO;
                    end else begin
                        s_d.st = ST_EMIT;
                    end
                end
            end
            ST_DLO: begin
                if (take) begin
                    s_d.rec.len = s_q.rec.len + LEN_W'(1);
                    if (s_q.rec.mode == 2'b01) begin
                        s_d.rec.disp = {{BYTE_W{in_byte[BYTE_W-1]}}, in_byte};
                    end else begin
                        s_d.rec.disp = {{BYTE_W{1'b0}}, in_byte};
                    end
                    if (n_disp == 2'd2) begin
                        s_d.st = ST_DHI;
                    end else if (s_q.rec.imm_form) begin
                        s_d.st = ST_ILO;
                    end else begin
                        s_d.st = ST_EMIT;
                    end
                end
            end
            ST_DHI: begin
                if (take) begin
                    s_d.rec.len                    = s_q.rec.len + LEN_W'(1);
                    s_d.rec.disp[WORD_W-1:BYTE_W]  = in_byte;
                    s_d.st = s_q.rec.imm_form ? ST_ILO : ST_EMIT;
                end
            end
            ST_ILO: begin
                if (take) begin
                    s_d.rec.len = s_q.rec.len + LEN_W'(1);
                    s_d.rec.imm = {{BYTE_W{1'b0}}, in_byte};
                    s_d.st      = s_q.rec.wide ? ST_IHI : ST_EMIT;
                end
            end
            ST_IHI: begin
                if (take) begin
                    s_d.rec.len                   = s_q.rec.len + LEN_W'(1);
                    s_d.rec.imm[WORD_W-1:BYTE_W]  = in_byte;
                    s_d.st                        = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    s_d.st = ST_OPC;
                end
            end
            default: s_d.st = ST_OPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.st  <= ST_OPC;
            s_q.rec <= '0;
            s_q.bad <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.st != ST_EMIT);
    assign out_valid = (s_q.st == ST_EMIT);
    assign rec       = s_q.rec;
    assign bad_op    = s_q.bad;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(rec))); // R10
    AST_NO_INTAKE_WHILE_FULL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && in_valid) |=> $stable(rec.len) || !out_valid); // R10
    AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rec.len >= LEN_W'(2) && rec.len <= LEN_W'(6))); // R7
    AST_BADOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> !out_valid); // R9
    AST_BYTE_IMM_NARROW: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !rec.wide) |-> (rec.imm[WORD_W-1:BYTE_W] == '0)); // R6

endmodule

// File: rtl/mov_stream_decoder.sv
module mov_stream_decoder
    import movdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        in_ready,
    input  logic [15:0] reg_bx,
    input  logic [15:0] reg_bp,
    input  logic [15:0] reg_si,
    input  logic [15:0] reg_di,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_illegal,
    output logic        out_dir,
    output logic        out_wide,
    output logic        out_imm_form,
    output logic [2:0]  out_reg,
    output logic        out_is_mem,
    output logic [1:0]  out_base_sel,
    output logic [1:0]  out_idx_sel,
    output logic        out_seg_ss,
    output logic [15:0] out_disp,
    output logic [15:0] out_imm,
    output logic [3:0]  out_len,
    output logic [15:0] out_ea
);

    rec_t rec_q;

    movdec_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .rec       (rec_q),
        .bad_op    (out_illegal)
    );

    movdec_rm_decode u_rm (
        .mode     (rec_q.mode),
        .rm       (rec_q.rm),
        .is_mem   (out_is_mem),
        .base_sel (out_base_sel),
        .idx_sel  (out_idx_sel),
        .seg_ss   (out_seg_ss)
    );

    movdec_ea_adder u_ea (
        .base_sel (out_base_sel),
        .idx_sel  (out_idx_sel),
        .reg_bx   (reg_bx),
        .reg_bp   (reg_bp),
        .reg_si   (reg_si),
        .reg_di   (reg_di),
        .disp     (rec_q.disp),
        .ea       (out_ea)
    );

    assign out_dir      = rec_q.dir;
    assign out_wide     = rec_q.wide;
    assign out_imm_form = rec_q.imm_form;
    assign out_reg      = rec_q.regf;
    assign out_disp     = rec_q.disp;
    assign out_imm      = rec_q.imm;
    assign out_len      = rec_q.len;

    AST_DIRECT_BARE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rec_q.mode == 2'b00 && rec_q.rm == 3'b110)
            |-> (out_base_sel == SEL_NONE && out_idx_sel == SEL_NONE && !out_seg_ss)); // R5
    AST_SS_MEANS_BP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_seg_ss) |-> (out_base_sel == BASE_BP)); // R4
    AST_REGMODE_NO_DISP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_mem) |-> (out_disp == '0 && out_ea == '0)); // R2
    AST_IMM_FORM_REG0: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_imm_form) |-> (out_reg == 3'b000 && !out_dir)); // R6

endmodule

// File: tb/tb_mov_stream_decoder.sv
`timescale 1ns/100ps
module tb_mov_stream_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic [15:0] reg_bx = 16'h1000;
    logic [15:0] reg_bp = 16'h2000;
    logic [15:0] reg_si = 16'h0030;
    logic [15:0] reg_di = 16'h0400;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_illegal;
    logic        out_dir, out_wide, out_imm_form, out_is_mem, out_seg_ss;
    logic [2:0]  out_reg;
    logic [1:0]  out_base_sel, out_idx_sel;
    logic [15:0] out_disp, out_imm, out_ea;
    logic [3:0]  out_len;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    mov_stream_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .out_valid(out_valid), .out_ready(out_ready), .out_illegal(out_illegal),
        .out_dir(out_dir), .out_wide(out_wide), .out_imm_form(out_imm_form),
        .out_reg(out_reg), .out_is_mem(out_is_mem), .out_base_sel(out_base_sel),
        .out_idx_sel(out_idx_sel), .out_seg_ss(out_seg_ss), .out_disp(out_disp),
        .out_imm(out_imm), .out_len(out_len), .out_ea(out_ea)
    );

    typedef struct packed {
        logic [3:0]  n;
        logic [47:0] bytes;
        logic        dir;
        logic        wide;
        logic [2:0]  rg;
        logic        mem;
        logic [1:0]  base;
        logic [1:0]  idx;
        logic        ss;
        logic [15:0] disp;
        logic [15:0] imm;
        logic [3:0]  len;
        logic [15:0] ea;
    } vec_t;

    // bytes are packed first-byte-in-bits-7:0; BX=1000 BP=2000 SI=0030 DI=0400
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 48'h0000_0000_EC8B, 1'b1, 1'b1, 3'd5, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h0000, 4'd2, 16'h0000},
        '{4'd2, 48'h0000_0000_158A, 1'b1, 1'b0, 3'd2, 1'b1, 2'd0, 2'd2, 1'b0, 16'h0000, 16'h0000, 4'd2, 16'h0400},
        '{4'd4, 48'h0000_1000_1688, 1'b0, 1'b0, 3'd2, 1'b1, 2'd0, 2'd0, 1'b0, 16'h1000, 16'h0000, 4'd4, 16'h1000},
        '{4'd3, 48'h0000_00F0_428B, 1'b1, 1'b1, 3'd0, 1'b1, 2'd2, 2'd1, 1'b1, 16'hFFF0, 16'h0000, 4'd3, 16'h2020},
        '{4'd4, 48'h0000_1234_9F89, 1'b0, 1'b1, 3'd3, 1'b1, 2'd1, 2'd0, 1'b0, 16'h1234, 16'h0000, 4'd4, 16'h2234},
        '{4'd6, 48'h1234_1000_80C7, 1'b0, 1'b1, 3'd0, 1'b1, 2'd1, 2'd1, 1'b0, 16'h1000, 16'h1234, 4'd6, 16'h2030},
        '{4'd4, 48'h0000_7F05_46C6, 1'b0, 1'b0, 3'd0, 1'b1, 2'd2, 2'd0, 1'b1, 16'h0005, 16'h007F, 4'd4, 16'h2005},
        '{4'd3, 48'h0000_00AA_C1C6, 1'b0, 1'b0, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0000, 16'h00AA, 4'd3, 16'h0000},
        '{4'd3, 48'h0000_0080_438B, 1'b1, 1'b1, 3'd0, 1'b1, 2'd2, 2'd2, 1'b1, 16'hFF80, 16'h0000, 4'd3, 16'h2380},
        '{4'd4, 48'h0000_FFFE_068A, 1'b1, 1'b0, 3'd0, 1'b1, 2'd0, 2'd0, 1'b0, 16'hFFFE, 16'h0000, 4'd4, 16'hFFFE},
        '{4'd4, 48'h0000_F000_808B, 1'b1, 1'b1, 3'd0, 1'b1, 2'd1, 2'd1, 1'b0, 16'hF000, 16'h0000, 4'd4, 16'h0030},
        '{4'd6, 48'hABCD_1234_06C7, 1'b0, 1'b1, 3'd0, 1'b1, 2'd0, 2'd0, 1'b0, 16'h1234, 16'hABCD, 4'd6, 16'h1234}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_bytes(input int n, input logic [47:0] b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = b[8*i +: 8];
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_rec(input vec_t v);
        chk("R10 out_valid", {31'd0, out_valid}, 32'd1);
        chk("R1 R6 dir/wide", {30'd0, out_dir, out_wide}, {30'd0, v.dir, v.wide});
        chk("R2 reg", {29'd0, out_reg}, {29'd0, v.rg});
        chk("R2 R4 R5 mem/base/idx/seg", {26'd0, out_is_mem, out_base_sel, out_idx_sel, out_seg_ss},
            {26'd0, v.mem, v.base, v.idx, v.ss});
        chk("R3 R5 disp", {16'd0, out_disp}, {16'd0, v.disp});
        chk("R6 imm", {16'd0, out_imm}, {16'd0, v.imm});
        chk("R7 len", {28'd0, out_len}, {28'd0, v.len});
        chk("R8 ea", {16'd0, out_ea}, {16'd0, v.ea});
    endtask

    task automatic release_rec();
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10 valid drops after accept", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk("R11 valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R11 ready after reset", {31'd0, in_ready}, 32'd1);
        chk("R11 illegal after reset", {31'd0, out_illegal}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            send_bytes(int'(VECS[k].n), VECS[k].bytes);
            check_rec(VECS[k]);
            release_rec();
        end

        // R10 hold: record held, bytes offered while waiting are not taken
        send_bytes(4, 48'h0000_1234_9F89);
        for (int c = 0; c < 3; c++) begin
            in_valid = 1'b1;
            in_byte  = 8'h8B;
            chk("R10 in_ready low while held", {31'd0, in_ready}, 32'd0);
            @(negedge clk);
            check_rec(VECS[4]);
        end
        in_valid = 1'b0;
        // R8 effective address follows live register inputs
        reg_bx = 16'h0100;
        #1;
        chk("R8 ea tracks BX", {16'd0, out_ea}, 32'h0000_1334);
        reg_bx = 16'h1000;
        release_rec();
        // bytes offered during hold were ignored: next instruction decodes cleanly
        send_bytes(2, 48'h0000_0000_158A);
        check_rec(VECS[1]);
        release_rec();

        // R9 illegal opcode pulses one cycle, then decoding resumes
        send_bytes(1, 48'h0000_0000_0090);
        chk("R9 illegal pulse", {31'd0, out_illegal}, 32'd1);
        @(negedge clk);
        chk("R9 illegal one cycle", {31'd0, out_illegal}, 32'd0);
        send_bytes(2, 48'h0000_0000_EC8B);
        check_rec(VECS[0]);
        release_rec();

        // R6 immediate form with nonzero REG is rejected
        send_bytes(2, 48'h0000_0000_08C7);
        chk("R6 bad REG flagged", {31'd0, out_illegal}, 32'd1);
        chk("R6 no record", {31'd0, out_valid}, 32'd0);
        send_bytes(3, 48'h0000_00AA_C1C6);
        check_rec(VECS[7]);
        release_rec();

        // R11 reset mid-instruction discards partial bytes
        send_bytes(1, 48'h0000_0000_008B);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 ready after mid reset", {31'd0, in_ready}, 32'd1);
        chk("R11 no record after mid reset", {31'd0, out_valid}, 32'd0);
        send_bytes(2, 48'h0000_0000_158A);
        check_rec(VECS[1]);
        release_rec();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule